// File: doc/BRIEF.md
# General Issue Queue

This block is a six-entry buffer that sits between instruction dispatch and four execution units: one complex integer unit, two simple integer units and one load/store unit. Dispatch may write up to three instructions per cycle into it. Each entry carries a unit-class code, a ready bit and an opaque tag. In every cycle the block looks only at its three oldest entries and issues any that are ready, in any order, to free units that can execute them. A younger ready instruction can therefore pass an older one that is stalled.

After issue, the entries that remain slide down to the bottom of the queue in their original age order. New arrivals are placed above them in the same cycle. The block reports its number of free slots to dispatch. A tag broadcast sets the ready bit of a waiting entry, and a flush empties the queue.

Top module: `gq_top`

## Requirements
- R1: After reset the queue is empty: `free_slots` reads 6 and `iss_valid` is 0 whatever `unit_busy` is.
- R2: In one cycle the queue accepts min(`in_num`, `free_slots`) arrivals, taken from slot 0 upward. Arrivals beyond that number are dropped. Slot j uses `in_kind[2j+1:2j]`, `in_ready[j]` and `in_tag[8j+7:8j]`.
- R3: Only the three oldest occupied entries can issue. A ready entry in position 3 or higher never issues.
- R4: Class code 0 (complex) issues only to unit 0. Code 2 (memory) issues only to unit 3. Code 1 (simple) tries unit 1 first, then unit 2, then unit 0. Units are numbered 0 complex, 1 simple A, 2 simple B, 3 load/store. `iss_tag[8u+7:8u]` carries the tag sent to unit u.
- R5: A unit whose `unit_busy` bit is set receives nothing. When two eligible entries compete for the same unit, the older one wins and the younger one waits.
- R6: When the oldest entry is a complex instruction and unit 0 is busy, ready simple and memory entries in the next two positions still issue to their own units.
- R7: Entries that do not issue keep their relative age order and move down to the lowest positions. Entries accepted in the same cycle are placed above them, in slot order.
- R8: When `wake_en` is set, every stored entry whose tag equals `wake_tag` becomes ready. The entry can issue from the next cycle on. A tag that matches no stored entry changes nothing.
- R9: `flush` empties the queue on the next edge and drops arrivals in the same cycle. During the flush cycle `iss_valid` is 0.
- R10: `free_slots` equals 6 minus the occupancy, and it updates one cycle after each issue or enqueue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue |
| in_num | input | 2 | Number of arrivals offered this cycle |
| in_kind | input | 6 | Class code per arrival slot |
| in_ready | input | 3 | Ready bit per arrival slot |
| in_tag | input | 24 | Tag per arrival slot |
| wake_en | input | 1 | Tag broadcast valid |
| wake_tag | input | 8 | Broadcast tag that sets ready bits |
| unit_busy | input | 4 | Per-unit busy flags |
| iss_valid | output | 4 | Per-unit issue strobe |
| iss_tag | output | 32 | Per-unit issued tag |
| free_slots | output | 3 | Empty entries available to dispatch |

## Verification
Issue and enqueue often happen in the same cycle. Compaction then has to close the gaps left by the issued entries while it writes the new arrivals above the survivors. The stimulus table provokes this by offering three arrivals while the window holds a mix of issuing and stalled entries, some with a busy complex unit. The result is judged in the following cycles: the stalled entry must stay at the bottom and issue first, and the arrivals must follow it in slot order, as seen on the unit strobes and tags. Flush and issue also meet in one cycle, and there the strobes must be low and the free count must return to 6.

// File: rtl/gq_pkg.sv
package gq_pkg;
   typedef enum logic [1:0] {
      KIND_CPLX = 2'd0,
      KIND_SIMP = 2'd1,
      KIND_MEM  = 2'd2,
      KIND_RSVD = 2'd3
   } kind_e;

   localparam int N_UNITS   = 4;
   localparam int UNIT_CPLX = 0;
   localparam int UNIT_SA   = 1;
   localparam int UNIT_SB   = 2;
   localparam int UNIT_LSU  = 3;
endpackage

// File: rtl/gq_select.sv
module gq_select
   import gq_pkg::*;
#(
   parameter int WIN   = 3,
   parameter bit SPILL = 1'b1,
   parameter int IW    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic [WIN-1:0]     cand,
   input  kind_e              kind [WIN],
   input  logic [N_UNITS-1:0] busy,
   output logic [WIN-1:0]     pick,
   output logic [N_UNITS-1:0] fire,
   output logic [IW-1:0]      src [N_UNITS]
);

   logic               spill_ok;
   logic [N_UNITS-1:0] taken;

   if (SPILL) begin : g_spill
      assign spill_ok = 1'b1;
   end else begin : g_nospill
      assign spill_ok = 1'b0;
   end

   // age-ordered greedy matching: position 0 is the oldest, so it claims first
   always_comb begin
      taken = busy;
      pick  = '0;
      fire  = '0;
      for (int u = 0; u < N_UNITS; u++) src[u] = '0;
      for (int i = 0; i < WIN; i++) begin
         if (cand[i] && !hold) begin
            case (kind[i])
               KIND_MEM: begin
                  if (!taken[UNIT_LSU]) begin
                     taken[UNIT_LSU] = 1'b1; fire[UNIT_LSU] = 1'b1;
                     src[UNIT_LSU] = IW'(i); pick[i] = 1'b1;
                  end
               end
               KIND_CPLX: begin
                  if (!taken[UNIT_CPLX]) begin
                     taken[UNIT_CPLX] = 1'b1; fire[UNIT_CPLX] = 1'b1;
                     src[UNIT_CPLX] = IW'(i); pick[i] = 1'b1;
                  end
               end
               KIND_SIMP: begin
                  if (!taken[UNIT_SA]) begin
                     taken[UNIT_SA] = 1'b1; fire[UNIT_SA] = 1'b1;
                     src[UNIT_SA] = IW'(i); pick[i] = 1'b1;
                  end else if (!taken[UNIT_SB]) begin
                     taken[UNIT_SB] = 1'b1; fire[UNIT_SB] = 1'b1;
                     src[UNIT_SB] = IW'(i); pick[i] = 1'b1;
                  end else if (spill_ok && !taken[UNIT_CPLX]) begin
                     taken[UNIT_CPLX] = 1'b1; fire[UNIT_CPLX] = 1'b1;
                     src[UNIT_CPLX] = IW'(i); pick[i] = 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_busy_unit_skipped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire & busy) == '0);

   assert_pick_fire_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pick) == $countones(fire));

   assert_oldest_mem_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cand[0] && !hold && kind[0] == KIND_MEM && !busy[UNIT_LSU])
         |-> (fire[UNIT_LSU] && src[UNIT_LSU] == '0));

   for (genvar w = 0; w < WIN; w++) begin : g_cplx_chk
      assert_cplx_to_unit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (pick[w] && kind[w] == KIND_CPLX)
            |-> (fire[UNIT_CPLX] && src[UNIT_CPLX] == IW'(w)));
   end

   if (WIN > 1) begin : g_bypass_chk
      assert_mem_passes_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!hold && cand[0] && kind[0] == KIND_CPLX && busy[UNIT_CPLX]
          && cand[1] && kind[1] == KIND_MEM && !busy[UNIT_LSU])
            |-> (fire[UNIT_LSU] && src[UNIT_LSU] == IW'(1)));
   end

endmodule

// File: rtl/gq_compact.sv
module gq_compact
   import gq_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int ENQ_W = 3,
   parameter int TAG_W = 8,
   parameter int CW    = 3,
   parameter int AW    = 3
) (
   input  logic [CW-1:0]    occ,
   input  logic [DEPTH-1:0] issued,
   input  kind_e            q_kind [DEPTH],
   input  logic [DEPTH-1:0] q_rdy,
   input  logic [TAG_W-1:0] q_tag [DEPTH],
   input  logic [CW-1:0]    acc,
   input  kind_e            a_kind [ENQ_W],
   input  logic [ENQ_W-1:0] a_rdy,
   input  logic [TAG_W-1:0] a_tag [ENQ_W],
   input  logic             wake_en,
   input  logic [TAG_W-1:0] wake_tag,
   output kind_e            n_kind [DEPTH],
   output logic [DEPTH-1:0] n_rdy,
   output logic [TAG_W-1:0] n_tag [DEPTH],
   output logic [CW-1:0]    n_occ
);

   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [CW-1:0] pos;

   // survivors first, in age order, then accepted arrivals above them
   always_comb begin
      pos   = '0;
      n_rdy = '0;
      for (int k = 0; k < DEPTH; k++) begin
         n_kind[k] = KIND_CPLX;
         n_tag[k]  = '0;
      end
      for (int i = 0; i < DEPTH; i++) begin
         if ((CW'(i) < occ) && !issued[i]) begin
            n_kind[pos[AW-1:0]] = q_kind[i];
            n_tag[pos[AW-1:0]]  = q_tag[i];
            n_rdy[pos[AW-1:0]]  = q_rdy[i] | (wake_en && (q_tag[i] == wake_tag));
            pos = pos + 1'b1;
         end
      end
      for (int j = 0; j < ENQ_W; j++) begin
         if ((CW'(j) < acc) && (pos < DEPTH_C)) begin
            n_kind[pos[AW-1:0]] = a_kind[j];
            n_tag[pos[AW-1:0]]  = a_tag[j];
            n_rdy[pos[AW-1:0]]  = a_rdy[j];
            pos = pos + 1'b1;
         end
      end
      n_occ = pos;
   end

endmodule

// File: rtl/gq_top.sv
module gq_top
   import gq_pkg::*;
#(
   parameter int DEPTH        = 6,
   parameter int WIN          = 3,
   parameter int ENQ_W        = 3,
   parameter int TAG_W        = 8,
   parameter bit SIMPLE_SPILL = 1'b1,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int EW = $clog2(ENQ_W + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [EW-1:0]            in_num,
   input  logic [2*ENQ_W-1:0]       in_kind,
   input  logic [ENQ_W-1:0]         in_ready,
   input  logic [TAG_W*ENQ_W-1:0]   in_tag,
   input  logic                     wake_en,
   input  logic [TAG_W-1:0]         wake_tag,
   input  logic [N_UNITS-1:0]       unit_busy,
   output logic [N_UNITS-1:0]       iss_valid,
   output logic [N_UNITS*TAG_W-1:0] iss_tag,
   output logic [CW-1:0]            free_slots
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int IW = (WIN > 1) ? $clog2(WIN) : 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (WIN < 1 || WIN > DEPTH) begin : g_bad_win
      $error("gq_top: issue window must lie between 1 and DEPTH");
   end
   if (ENQ_W < 1 || ENQ_W > DEPTH) begin : g_bad_enq
      $error("gq_top: enqueue width must lie between 1 and DEPTH");
   end

   // storage
   logic [CW-1:0]    occ;
   kind_e            q_kind [DEPTH];
   logic [DEPTH-1:0] q_rdy;
   logic [TAG_W-1:0] q_tag [DEPTH];

   kind_e            n_kind [DEPTH];
   logic [DEPTH-1:0] n_rdy;
   logic [TAG_W-1:0] n_tag [DEPTH];
   logic [CW-1:0]    n_occ;

   // arrival unpacking
   kind_e            a_kind [ENQ_W];
   logic [TAG_W-1:0] a_tag [ENQ_W];
   for (genvar j = 0; j < ENQ_W; j++) begin : g_arr
      assign a_kind[j] = kind_e'(in_kind[2*j +: 2]);
      assign a_tag[j]  = in_tag[TAG_W*j +: TAG_W];
   end

   logic [CW-1:0] num_w;
   logic [CW-1:0] acc;
   assign free_slots = DEPTH_C - occ;
   assign num_w      = CW'(in_num);
   assign acc        = (num_w > free_slots) ? free_slots : num_w;

   // issue window
   logic [WIN-1:0]     cand;
   kind_e              w_kind [WIN];
   logic [WIN-1:0]     pick;
   logic [IW-1:0]      src [N_UNITS];
   logic [DEPTH-1:0]   issued;

   for (genvar w = 0; w < WIN; w++) begin : g_win
      assign cand[w]   = (CW'(w) < occ) && q_rdy[w];
      assign w_kind[w] = q_kind[w];
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_iss_mask
      if (i < WIN) begin : g_in
         assign issued[i] = pick[i];
      end else begin : g_out
         assign issued[i] = 1'b0;
      end
   end

   gq_select #(.WIN(WIN), .SPILL(SIMPLE_SPILL), .IW(IW)) u_sel (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (flush),
      .cand (cand),
      .kind (w_kind),
      .busy (unit_busy),
      .pick (pick),
      .fire (iss_valid),
      .src  (src)
   );

   for (genvar u = 0; u < N_UNITS; u++) begin : g_out_tag
      assign iss_tag[TAG_W*u +: TAG_W] = q_tag[AW'(src[u])];
   end

   gq_compact #(.DEPTH(DEPTH), .ENQ_W(ENQ_W), .TAG_W(TAG_W), .CW(CW), .AW(AW)) u_cmp (
      .occ     (occ),
      .issued  (issued),
      .q_kind  (q_kind),
      .q_rdy   (q_rdy),
      .q_tag   (q_tag),
      .acc     (acc),
      .a_kind  (a_kind),
      .a_rdy   (in_ready),
      .a_tag   (a_tag),
      .wake_en (wake_en),
      .wake_tag(wake_tag),
      .n_kind  (n_kind),
      .n_rdy   (n_rdy),
      .n_tag   (n_tag),
      .n_occ   (n_occ)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     occ <= '0;
      else if (flush) occ <= '0;
      else            occ <= n_occ;
   end

   always_ff @(posedge clk) begin
      q_kind <= n_kind;
      q_rdy  <= n_rdy;
      q_tag  <= n_tag;
   end

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= DEPTH_C);

   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (free_slots == DEPTH_C));

   assert_occupancy_balance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(flush))
         |-> (int'(occ) == int'($past(occ)) - $countones($past(pick)) + int'($past(acc))));

   assert_oldest_stays_put_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (occ != '0 && !pick[0] && !flush) |=> (q_tag[0] == $past(q_tag[0])));

   for (genvar u = 0; u < N_UNITS; u++) begin : g_win_chk
      assert_issue_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[u] |-> ((int'(src[u]) < WIN) && (CW'(src[u]) < occ)));
   end

endmodule

// File: tb/gq_top_test.sv
module gq_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  in_num = '0;
   logic [5:0]  in_kind = '0;
   logic [2:0]  in_ready = '0;
   logic [23:0] in_tag = '0;
   logic        wake_en = 1'b0;
   logic [7:0]  wake_tag = '0;
   logic [3:0]  unit_busy = '0;
   logic [3:0]  iss_valid;
   logic [31:0] iss_tag;
   logic [2:0]  free_slots;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   gq_top uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_num(in_num),
      .in_kind(in_kind), .in_ready(in_ready), .in_tag(in_tag),
      .wake_en(wake_en), .wake_tag(wake_tag), .unit_busy(unit_busy),
      .iss_valid(iss_valid), .iss_tag(iss_tag), .free_slots(free_slots)
   );

   typedef struct packed {
      logic        fl;
      logic [1:0]  n;
      logic [5:0]  kinds;
      logic [2:0]  rdy;
      logic [23:0] tags;
      logic [3:0]  busy;
      logic        wk;
      logic [7:0]  wtag;
      logic [3:0]  ev;
      logic [31:0] etag;
      logic [2:0]  efree;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 22;
   // class codes: 0 complex, 1 simple, 2 memory; units: 0 CX, 1 SA, 2 SB, 3 LSU
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0000, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd6, 4'd1},  // R1 empty
      '{1'b0, 2'd3, 6'b100100, 3'b111, 24'h131211, 4'b1111, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd6, 4'd2},  // R2 fill three
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b1111, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd3, 4'd5},  // R5 all busy
      '{1'b0, 2'd3, 6'b000101, 3'b011, 24'h232221, 4'b0001, 1'b0, 8'h00, 4'b1010, 32'h13001200, 3'd3, 4'd6},  // R6 bypass + enqueue
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0000, 1'b0, 8'h00, 4'b0111, 32'h00222111, 3'd2, 4'd7},  // R7 survivor oldest
      '{1'b0, 2'd3, 6'b101001, 3'b111, 24'h333231, 4'b0000, 1'b1, 8'h23, 4'b0000, 32'h00000000, 3'd5, 4'd8},  // R8 wake 23
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0000, 1'b0, 8'h00, 4'b1011, 32'h32003123, 3'd2, 4'd8},  // R8 woken issues
      '{1'b0, 2'd3, 6'b011010, 3'b111, 24'h434241, 4'b0000, 1'b0, 8'h00, 4'b1000, 32'h33000000, 3'd5, 4'd7},  // R7
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0000, 1'b0, 8'h00, 4'b1010, 32'h41004300, 3'd3, 4'd5},  // R5 older mem wins
      '{1'b0, 2'd3, 6'b010101, 3'b111, 24'h535251, 4'b0000, 1'b0, 8'h00, 4'b1000, 32'h42000000, 3'd5, 4'd7},  // R7 loser next
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0000, 1'b0, 8'h00, 4'b0111, 32'h00525153, 3'd3, 4'd4},  // R4 spill to CX
      '{1'b0, 2'd3, 6'b000000, 3'b000, 24'h636261, 4'b0000, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd6, 4'd2},  // R2
      '{1'b0, 2'd3, 6'b011001, 3'b111, 24'h666564, 4'b0000, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd3, 4'd2},  // R2
      '{1'b0, 2'd2, 6'b000101, 3'b011, 24'h007271, 4'b0000, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd0, 4'd3},  // R3 ready above window
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0000, 1'b1, 8'h62, 4'b0000, 32'h00000000, 3'd0, 4'd3},  // R3 full, drop
      '{1'b0, 2'd1, 6'b000001, 3'b001, 24'h000081, 4'b0000, 1'b0, 8'h00, 4'b0001, 32'h00000062, 3'd0, 4'd8},  // R8 middle entry
      '{1'b0, 2'd2, 6'b000110, 3'b011, 24'h009291, 4'b0000, 1'b0, 8'h00, 4'b0010, 32'h00006400, 3'd1, 4'd2},  // R2 partial accept
      '{1'b1, 2'd3, 6'b010101, 3'b111, 24'hC3C2C1, 4'b0000, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd1, 4'd9},  // R9 flush masks issue
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0000, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd6, 4'd9},  // R9 emptied
      '{1'b0, 2'd1, 6'b000001, 3'b001, 24'h0000A1, 4'b0000, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd6, 4'd2},  // R2
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0010, 1'b0, 8'h00, 4'b0100, 32'h00A10000, 3'd5, 4'd5},  // R5 SA busy -> SB
      '{1'b0, 2'd0, 6'b000000, 3'b000, 24'h000000, 4'b0000, 1'b0, 8'h00, 4'b0000, 32'h00000000, 3'd6, 4'd10}  // R10 drained
   };

   task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         flush     = VECS[v].fl;
         in_num    = VECS[v].n;
         in_kind   = VECS[v].kinds;
         in_ready  = VECS[v].rdy;
         in_tag    = VECS[v].tags;
         unit_busy = VECS[v].busy;
         wake_en   = VECS[v].wk;
         wake_tag  = VECS[v].wtag;
         #2;
         chk($sformatf("vec %0d free", v), int'(VECS[v].req), 32'(free_slots), 32'(VECS[v].efree));
         chk($sformatf("vec %0d valid", v), int'(VECS[v].req), 32'(iss_valid), 32'(VECS[v].ev));
         for (int u = 0; u < 4; u++) begin
            if (VECS[v].ev[u])
               chk($sformatf("vec %0d unit %0d tag", v, u), int'(VECS[v].req),
                   32'(iss_tag[8*u +: 8]), 32'(VECS[v].etag[8*u +: 8]));
         end
      end

      // R1: reset clears a loaded queue
      @(negedge clk);
      in_num = 2'd2; in_kind = 6'b001000; in_ready = 3'b011; in_tag = 24'h00E2E1;
      unit_busy = 4'b1111; wake_en = 1'b0; flush = 1'b0;
      @(negedge clk);
      in_num = 2'd0;
      #2;
      chk("loaded before reset free", 2, 32'(free_slots), 32'd4);  // R2
      rst_n = 1'b0;
      unit_busy = 4'b0000;
      #1;
      chk("reset free", 1, 32'(free_slots), 32'd6);    // R1
      chk("reset valid", 1, 32'(iss_valid), 32'd0);    // R1
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk("after reset free", 1, 32'(free_slots), 32'd6);  // R1
      chk("after reset valid", 1, 32'(iss_valid), 32'd0);  // R1

      // R8: non-matching wake leaves entry waiting, matching one releases it
      @(negedge clk);
      in_num = 2'd1; in_kind = 6'b000000; in_ready = 3'b000; in_tag = 24'h000077;
      @(negedge clk);
      in_num = 2'd0; wake_en = 1'b1; wake_tag = 8'h78;
      #2;
      chk("not ready entry held", 8, 32'(iss_valid), 32'd0);  // R8
      @(negedge clk);
      wake_tag = 8'h77;
      #2;
      chk("wrong tag ignored", 8, 32'(iss_valid), 32'd0);     // R8
      @(negedge clk);
      wake_en = 1'b0;
      #2;
      chk("woken valid", 8, 32'(iss_valid), 32'd1);           // R8
      chk("woken tag", 8, 32'(iss_tag[7:0]), 32'h77);         // R8
      @(negedge clk);
      #2;
      chk("drained free", 10, 32'(free_slots), 32'd6);        // R10

      finish_run();
   end

endmodule